// File: doc/BRIEF.md
# Bus Transaction Error Status Monitor

This block sits beside the receive engine of a bus master and turns its per-transaction progress and error events into sticky status flags. Four conditions are tracked: the engine's state machine reaching a state that is not legal, a transaction needing more retries than a programmable limit allows, the addressed target aborting, and no target answering (the master gives up on its own). Each flag has its own interrupt enable, and the enabled flags merge into a single registered interrupt line.

The retry count runs per transaction. It clears when a new transaction starts, so retries never pile up across a packet. A limit of zero turns the retry check off. Software clears flags by writing ones. The system-error flag is harder to clear: the controller reset must have been requested first. Abort events only set flags. They never touch the retry progress of the transaction in flight.

Top module: `txn_err_monitor`

## Requirements
- R1: While reset is held and after it is released, `status_o` is all zero and `irq_o` is low until an event arrives.
- R2: With `retry_limit_i` = L (1 to 255), the retry-error flag (status bit 1) stays clear through L retry pulses of one transaction. It reads one in the cycle after the clock edge that samples retry pulse L+1.
- R3: With `retry_limit_i` = 0, the retry-error flag never sets, however many retries arrive.
- R4: A `txn_start_i` pulse zeroes the retry count. If a retry pulse comes in the same cycle as a start, it counts as the first retry of the new transaction.
- R5: Each event sets its flag, visible one cycle after the sampling edge. An illegal-state indication sets bit 0, a target abort sets bit 2, and an initiator abort (no target responded) sets bit 3.
- R6: Flags are sticky. A write with `clr_we_i` high clears every flag in bits 1 to 3 whose `clr_data_i` bit is one. Flags whose data bit is zero keep their value.
- R7: If a set event and a clear of the same flag arrive in the same cycle, the flag stays set.
- R8: A clear of the system-error flag (bit 0) has no effect unless `ctrl_reset_i` was high in an earlier cycle while the flag was set. An accepted clear uses up that arming, so the next system error again needs a controller reset before it can be cleared.
- R9: `irq_o` is the OR over all flags of flag AND its enable bit in `irq_en_i` (same bit positions as the status flags). It is registered, so it follows a change one clock later.
- R10: Abort events leave the retry count alone. Retries after an abort keep counting toward the limit of the same transaction.
- R11: Status bits 4 and up always read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously inside |
| txn_start_i | input | 1 | Pulse: a new transaction begins |
| retry_i | input | 1 | Pulse: the current transaction is retried |
| tabort_i | input | 1 | Pulse: the target aborted |
| iabort_i | input | 1 | Pulse: no target responded |
| illegal_state_i | input | 1 | The engine's state machine is in an illegal state |
| retry_limit_i | input | LIM_W (8) | Retry limit per transaction, 0 = unlimited |
| irq_en_i | input | 4 | Per-flag interrupt enables |
| ctrl_reset_i | input | 1 | Controller-reset request, arms the system-error clear |
| clr_we_i | input | 1 | Status write strobe |
| clr_data_i | input | STAT_W (16) | Write data, a one clears the matching flag |
| status_o | output | STAT_W (16) | Sticky status flags |
| irq_o | output | 1 | Registered interrupt |

## Verification
The embedded properties check, on every cycle, that set wins over clear, that flags hold without a clear, that the system error cannot drop while unarmed, that the retry count steps, holds and restarts, that an unlimited limit never raises the retry flag, and that the interrupt lags the enabled flags by exactly one clock. What only the bench scenarios can show is the exact cycle in which each limit from 1 to 255 is crossed, the handling of a start and a retry arriving together, retry progress surviving aborts, the full recovery sequence for a system error, and the interrupt output for every enable mask.

// File: rtl/err_mon_pkg.sv
package err_mon_pkg;

  localparam int unsigned N_FLAG = 4;

  typedef enum logic [1:0] {
    FLG_SYS   = 2'd0,
    FLG_RETRY = 2'd1,
    FLG_TABT  = 2'd2,
    FLG_IABT  = 2'd3
  } flag_idx_e;

  typedef logic [N_FLAG-1:0] flag_vec_t;

endpackage

// File: rtl/err_rst_sync.sv
module err_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/err_retry_tracker.sv
module err_retry_tracker #(
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txn_start_i,
  input  logic             retry_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             over_o
);

  localparam int unsigned CNT_W = LIM_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] base;
  logic             cnt_en;
  logic             lim_on;

  always_comb begin
    base   = txn_start_i ? '0 : cnt_q;
    cnt_en = txn_start_i | retry_i;
    cnt_d  = base;
    if (retry_i && (base != CNT_MAX)) begin
      cnt_d = base + 1'b1;
    end
    lim_on = (limit_i != '0);
    over_o = retry_i && lim_on && (base >= {1'b0, limit_i});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R4: a start without a retry leaves the count at zero
  a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_start_i && !retry_i) |=> (cnt_q == '0));

  // R2: a retry inside a transaction advances the count by one
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!txn_start_i && retry_i && (cnt_q != CNT_MAX)) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R10: with no start and no retry the count is frozen (aborts cannot move it)
  a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!txn_start_i && !retry_i) |=> $stable(cnt_q));

endmodule

// File: rtl/err_flag_cell.sv
module err_flag_cell #(
  parameter bit NEEDS_ARM = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic arm_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;
  logic clr_ok;

  generate
    if (NEEDS_ARM) begin : g_armed
      logic armed_q;
      logic armed_d;

      always_comb begin
        clr_ok  = clr_i && armed_q;
        armed_d = armed_q;
        if (clr_ok) begin
          armed_d = 1'b0;
        end else if (arm_i && flag_q) begin
          armed_d = 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          armed_q <= 1'b0;
        end else begin
          armed_q <= armed_d;
        end
      end

      // R8: an unarmed system-error flag cannot be cleared
      a_r8_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !armed_q) |=> flag_q);
    end else begin : g_plain
      logic unused_arm;
      assign unused_arm = arm_i;
      always_comb begin
        clr_ok = clr_i;
      end
    end
  endgenerate

  always_comb begin
    flag_d = flag_q;
    if (set_i) begin
      flag_d = 1'b1;
    end else if (clr_ok) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R7: an event in the same cycle as a clear leaves the flag set
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);

  // R6: without a clear request a set flag stays set
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);

endmodule

// File: rtl/err_irq_merge.sv
module err_irq_merge #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);

  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = |(flags_i & en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/txn_err_monitor.sv
module txn_err_monitor
  import err_mon_pkg::*;
#(
  parameter int unsigned LIM_W  = 8,
  parameter int unsigned STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start_i,
  input  logic              retry_i,
  input  logic              tabort_i,
  input  logic              iabort_i,
  input  logic              illegal_state_i,
  input  logic [LIM_W-1:0]  retry_limit_i,
  input  logic [N_FLAG-1:0] irq_en_i,
  input  logic              ctrl_reset_i,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] clr_data_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);

  logic      rst_int_n;
  logic      retry_over;
  flag_vec_t set_vec;
  flag_vec_t clr_vec;
  flag_vec_t flags;
  logic      unused_clr_hi;

  err_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_int_n)
  );

  err_retry_tracker #(.LIM_W(LIM_W)) u_retry (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .txn_start_i (txn_start_i),
    .retry_i     (retry_i),
    .limit_i     (retry_limit_i),
    .over_o      (retry_over)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[FLG_SYS]   = illegal_state_i;
    set_vec[FLG_RETRY] = retry_over;
    set_vec[FLG_TABT]  = tabort_i;
    set_vec[FLG_IABT]  = iabort_i;
    clr_vec            = clr_we_i ? clr_data_i[N_FLAG-1:0] : '0;
  end

  assign unused_clr_hi = ^clr_data_i[STAT_W-1:N_FLAG];

  generate
    for (genvar i = 0; i < int'(N_FLAG); i++) begin : g_flag
      err_flag_cell #(.NEEDS_ARM(i == int'(FLG_SYS))) u_cell (
        .clk    (clk),
        .rst_n  (rst_int_n),
        .set_i  (set_vec[i]),
        .clr_i  (clr_vec[i]),
        .arm_i  (ctrl_reset_i),
        .flag_o (flags[i])
      );
    end
  endgenerate

  err_irq_merge #(.N(N_FLAG)) u_irq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .flags_i (flags),
    .en_i    (irq_en_i),
    .irq_o   (irq_o)
  );

  always_comb begin
    status_o              = '0;
    status_o[N_FLAG-1:0]  = flags;
  end

  // R9: the interrupt follows the enabled flags one clock later
  a_r9_irq_lag: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o == $past(|(status_o[N_FLAG-1:0] & irq_en_i)));

  // R3: with an unlimited limit the retry flag cannot rise
  a_r3_unlimited: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((retry_limit_i == '0) && !status_o[FLG_RETRY]) |=> !status_o[FLG_RETRY]);

  // R5: an abort shows in its flag on the next cycle
  a_r5_abort_flags: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tabort_i || iabort_i) |=> (status_o[FLG_TABT] || status_o[FLG_IABT]));

endmodule

// File: tb/sim_txn_err_monitor.sv
`timescale 1ns/1ps
module sim_txn_err_monitor;

  localparam int LIM_W  = 8;
  localparam int STAT_W = 16;

  logic              clk;
  logic              rst_n;
  logic              txn_start_i, retry_i, tabort_i, iabort_i, illegal_state_i;
  logic [LIM_W-1:0]  retry_limit_i;
  logic [3:0]        irq_en_i;
  logic              ctrl_reset_i, clr_we_i;
  logic [STAT_W-1:0] clr_data_i;
  logic [STAT_W-1:0] status_o;
  logic              irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  txn_err_monitor #(.LIM_W(LIM_W), .STAT_W(STAT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .txn_start_i(txn_start_i), .retry_i(retry_i),
    .tabort_i(tabort_i), .iabort_i(iabort_i), .illegal_state_i(illegal_state_i),
    .retry_limit_i(retry_limit_i), .irq_en_i(irq_en_i), .ctrl_reset_i(ctrl_reset_i),
    .clr_we_i(clr_we_i), .clr_data_i(clr_data_i), .status_o(status_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_txn();
    txn_start_i = 1'b1; step(); txn_start_i = 1'b0;
  endtask

  task automatic write_clr(input logic [STAT_W-1:0] d);
    clr_we_i = 1'b1; clr_data_i = d; step(); clr_we_i = 1'b0; clr_data_i = '0;
  endtask

  initial begin
    rst_n = 1'b0; txn_start_i = 0; retry_i = 0; tabort_i = 0; iabort_i = 0;
    illegal_state_i = 0; retry_limit_i = '0; irq_en_i = '0; ctrl_reset_i = 0;
    clr_we_i = 0; clr_data_i = '0;
    repeat (4) step();
    chk("R1 status in reset", status_o, 0);
    chk("R1 irq in reset", irq_o, 0);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R1 status after reset", status_o, 0);
    chk("R1 irq after reset", irq_o, 0);

    // R2: sweep every finite limit
    for (int lim = 1; lim < 256; lim++) begin
      retry_limit_i = lim[LIM_W-1:0];
      start_txn();
      retry_i = 1'b1;
      repeat (lim) step();
      chk($sformatf("R2 limit %0d at limit", lim), status_o[1], 0);
      step();
      retry_i = 1'b0;
      chk($sformatf("R2 limit %0d beyond limit", lim), status_o[1], 1);
      write_clr(16'h0002);
    end

    // R3: zero limit, many retries
    retry_limit_i = '0;
    start_txn();
    retry_i = 1'b1;
    repeat (600) step();
    retry_i = 1'b0;
    chk("R3 unlimited retries", status_o, 0);

    // R4: start clears count; start with retry counts as first
    retry_limit_i = 8'd3;
    start_txn();
    retry_i = 1'b1; repeat (3) step();
    txn_start_i = 1'b1; step(); txn_start_i = 1'b0;
    step(); step();
    chk("R4 count restarted", status_o[1], 0);
    step(); retry_i = 1'b0;
    chk("R4 start+retry counted as first", status_o[1], 1);
    write_clr(16'h0002);
    chk("R6 retry flag cleared", status_o, 0);

    // R10 and R5: aborts do not disturb retry progress
    retry_limit_i = 8'd2;
    start_txn();
    retry_i = 1'b1; repeat (2) step(); retry_i = 1'b0;
    tabort_i = 1'b1; step(); tabort_i = 1'b0;
    chk("R5 target abort bit 2", status_o, 16'h0004);
    iabort_i = 1'b1; step(); iabort_i = 1'b0;
    chk("R5 initiator abort bit 3", status_o, 16'h000C);
    retry_i = 1'b1; step(); retry_i = 1'b0;
    chk("R10 retry after aborts crosses limit", status_o, 16'h000E);

    // R6: zeros in write data leave flags
    write_clr(16'h0008);
    chk("R6 partial clear", status_o, 16'h0006);

    // R7: set and clear in the same cycle
    tabort_i = 1'b1; clr_we_i = 1'b1; clr_data_i = 16'h0004; step();
    tabort_i = 1'b0; clr_we_i = 1'b0; clr_data_i = '0;
    chk("R7 set wins over clear", status_o, 16'h0006);

    // R11: upper bits ignore writes and read zero
    write_clr(16'hFFF0);
    chk("R11 upper bits zero", status_o, 16'h0006);

    // R5: illegal state sets bit 0; restore bit 3
    illegal_state_i = 1'b1; iabort_i = 1'b1; step();
    illegal_state_i = 1'b0; iabort_i = 1'b0;
    chk("R5 system error bit 0", status_o, 16'h000F);

    // R9: latency, then every mask with all flags set
    irq_en_i = 4'b0000; step();
    irq_en_i = 4'b0100;
    chk("R9 irq before edge", irq_o, 0);
    step();
    chk("R9 irq one cycle later", irq_o, 1);
    for (int m = 0; m < 16; m++) begin
      irq_en_i = m[3:0]; step();
      chk($sformatf("R9 all flags mask %0h", m), irq_o, (m != 0));
    end
    write_clr(16'h000E);
    chk("R8 unarmed clear keeps bit 0", status_o, 16'h0001);
    for (int m = 0; m < 16; m++) begin
      irq_en_i = m[3:0]; step();
      chk($sformatf("R9 sys only mask %0h", m), irq_o, m[0]);
    end
    irq_en_i = '0;

    // R8: recovery sequence
    ctrl_reset_i = 1'b1; step(); ctrl_reset_i = 1'b0;
    chk("R8 reset alone keeps flag", status_o, 16'h0001);
    write_clr(16'h0001);
    chk("R8 armed clear", status_o, 16'h0000);
    illegal_state_i = 1'b1; step(); illegal_state_i = 1'b0;
    write_clr(16'h0001);
    chk("R8 arming used up", status_o, 16'h0001);
    ctrl_reset_i = 1'b1; clr_we_i = 1'b1; clr_data_i = 16'h0001; step();
    ctrl_reset_i = 1'b0; clr_we_i = 1'b0; clr_data_i = '0;
    chk("R8 same-cycle reset does not clear", status_o, 16'h0001);
    write_clr(16'h0001);
    chk("R8 clear after earlier reset", status_o, 16'h0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule